// File: doc/BRIEF.md
# SMBASE RAM Lock Negotiator

This block owns a single byte of configuration state that lets boot firmware find out whether a protected RAM window at the legacy SMBASE address is available, and then seal it. Firmware first writes a query value. The block answers with an "available in RAM" status and, from then on, accepts only the lock bit. Setting the lock bit removes that bit's own write permission, so the byte can never change again until reset. Any write made before the query is thrown away, and the byte returns to zero.

Once the lock is set, every memory access whose address falls in the 64 KB window at 0x30000–0x3FFFF is routed according to the SMM qualifier of the requesting master. An access without SMM is steered to a sink: its writes are dropped and its reads return all-ones. An access with SMM is steered to the backing RAM. A strap input removes the feature: with the strap low, the byte ignores every write and the window is never claimed.

Top module: `smlk_top`

## Requirements
- R1: After reset the configuration byte reads 0x00 and no access is routed to the sink or to the protected RAM.
- R2: While `feat_en` is low, configuration writes leave the byte unchanged (0x00 after reset) and the window is never claimed.
- R3: Before the query has been answered, a write of any value other than the query value 0xFF leaves the byte at 0x00, and a lock bit written in this phase has no effect.
- R4: A write of 0xFF while no query has been answered makes the byte read the answer value 0x01. From then on only bit 1 is writable, so writing 0x00 or 0xFC still reads 0x01.
- R5: After the answer, a write with bit 1 (the lock bit) set makes the byte read exactly 0x02 and seals the window.
- R6: Once sealed, no write changes the byte: it keeps reading 0x02 until reset.
- R7: While sealed, a valid access by a non-SMM master inside the window asserts `sink_sel`, keeps `smram_sel` low and drives `hole_rdata` to all-ones.
- R8: While sealed, a valid access by an SMM master inside the window asserts `smram_sel` and keeps `sink_sel` low.
- R9: Addresses below 0x30000 or at or above 0x40000, accesses with `mem_valid` low, and any access while not sealed assert neither routing output. `win_hit` reflects only the address compare.
- R10: A second write of 0xFF after the answer is merged through the narrowed write mask, sets the lock bit and seals the window (the byte reads 0x02).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| feat_en | input | 1 | Feature-present strap |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Current configuration byte |
| mem_valid | input | 1 | Memory access valid |
| mem_smm | input | 1 | Access is made by a master in SMM |
| mem_addr | input | 32 | Memory access byte address |
| win_hit | output | 1 | Address lies inside the protected window |
| sink_sel | output | 1 | Route the access to the sink (writes dropped, reads all-ones) |
| smram_sel | output | 1 | Route the access to the protected RAM |
| hole_rdata | output | 32 | Read data for sink-routed reads |

## Verification
The bench aims at the ordering of the handshake: a lock bit written before the query must be lost, and a design that honoured it would seal the window without negotiation. After the answer it writes values with other bits set, and a design that failed to narrow the write mask would read back something other than 0x01. A second 0xFF write after the answer must seal the window, and a design that treated it as a new query would return to 0x01. The window edges at 0x2FFFF, 0x30000, 0x3FFFF and 0x40000, together with both SMM polarities, show whether the compare is off by one and whether the routing is inverted.

// File: rtl/smlk_pkg.sv
package smlk_pkg;

  localparam int unsigned CFG_W = 8;

  localparam logic [CFG_W-1:0] QUERY_VAL  = 8'hFF;
  localparam logic [CFG_W-1:0] ANSWER_VAL = 8'h01;
  localparam int unsigned      LOCK_BIT   = 1;
  localparam logic [CFG_W-1:0] LOCK_VAL   = 8'h02;
  localparam logic [CFG_W-1:0] MASK_FULL  = '1;

  typedef enum logic [1:0] {
    PH_OPEN     = 2'd0,
    PH_ANSWERED = 2'd1,
    PH_LOCKED   = 2'd2
  } smlk_phase_e;

endpackage

// File: rtl/smlk_rst_sync.sv
module smlk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_q_n = chain_q[STAGES-1];

endmodule

// File: rtl/smlk_cfg_byte.sv
module smlk_cfg_byte
  import smlk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             feat_en,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output logic [CFG_W-1:0] rd_data,
  output logic             region_en,
  output smlk_phase_e      phase
);

  logic [CFG_W-1:0] data_q, data_d;
  logic [CFG_W-1:0] mask_q, mask_d;
  logic [CFG_W-1:0] merged;
  logic             upd_en;

  // write merge through the current write mask
  assign merged = (data_q & ~mask_q) | (wr_data & mask_q);
  assign upd_en = feat_en & wr_en;

  always_comb begin
    data_d = data_q;
    mask_d = mask_q;
    if (merged == QUERY_VAL) begin
      data_d = ANSWER_VAL;
      mask_d = LOCK_VAL;
    end else if (mask_q == MASK_FULL) begin
      data_d = '0;
    end else if (merged[LOCK_BIT]) begin
      data_d = LOCK_VAL;
      mask_d = mask_q & ~LOCK_VAL;
    end else begin
      data_d = merged;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      mask_q <= MASK_FULL;
    end else if (upd_en) begin
      data_q <= data_d;
      mask_q <= mask_d;
    end
  end

  always_comb begin
    if (mask_q == MASK_FULL) begin
      phase = PH_OPEN;
    end else if (mask_q[LOCK_BIT]) begin
      phase = PH_ANSWERED;
    end else begin
      phase = PH_LOCKED;
    end
  end

  assign rd_data   = data_q;
  assign region_en = feat_en & data_q[LOCK_BIT];

endmodule

// File: rtl/smlk_win_dec.sv
module smlk_win_dec #(
  parameter int unsigned         AW        = 32,
  parameter int unsigned         DW        = 32,
  parameter logic [AW-1:0]       WIN_BASE  = 32'h0003_0000,
  parameter int unsigned         WIN_LOG2  = 16
) (
  input  logic          region_en,
  input  logic          mem_valid,
  input  logic          mem_smm,
  input  logic [AW-1:0] mem_addr,
  output logic          win_hit,
  output logic          sink_sel,
  output logic          smram_sel,
  output logic [DW-1:0] hole_rdata
);

  localparam int unsigned TAG_W = AW - WIN_LOG2;
  localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[AW-1:WIN_LOG2];

  logic claim;

  assign win_hit   = (mem_addr[AW-1:WIN_LOG2] == WIN_TAG);
  assign claim     = region_en & mem_valid & win_hit;
  assign sink_sel  = claim & ~mem_smm;
  assign smram_sel = claim & mem_smm;
  assign hole_rdata = sink_sel ? {DW{1'b1}} : '0;

endmodule

// File: rtl/smlk_top.sv
module smlk_top
  import smlk_pkg::*;
#(
  parameter int unsigned   AW       = 32,
  parameter int unsigned   DW       = 32,
  parameter logic [AW-1:0] WIN_BASE = 32'h0003_0000,
  parameter int unsigned   WIN_LOG2 = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             feat_en,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             mem_valid,
  input  logic             mem_smm,
  input  logic [AW-1:0]    mem_addr,
  output logic             win_hit,
  output logic             sink_sel,
  output logic             smram_sel,
  output logic [DW-1:0]    hole_rdata
);

  logic        rst_q_n;
  logic        region_en;
  smlk_phase_e phase;

  smlk_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  smlk_cfg_byte u_cfg (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .feat_en   (feat_en),
    .wr_en     (cfg_wr),
    .wr_data   (cfg_wdata),
    .rd_data   (cfg_rdata),
    .region_en (region_en),
    .phase     (phase)
  );

  smlk_win_dec #(
    .AW       (AW),
    .DW       (DW),
    .WIN_BASE (WIN_BASE),
    .WIN_LOG2 (WIN_LOG2)
  ) u_dec (
    .region_en  (region_en),
    .mem_valid  (mem_valid),
    .mem_smm    (mem_smm),
    .mem_addr   (mem_addr),
    .win_hit    (win_hit),
    .sink_sel   (sink_sel),
    .smram_sel  (smram_sel),
    .hole_rdata (hole_rdata)
  );

endmodule

// File: rtl/smlk_chk.sv
module smlk_chk
  import smlk_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic             feat_en,
  input logic             cfg_wr,
  input logic [CFG_W-1:0] cfg_wdata,
  input logic [CFG_W-1:0] cfg_rdata,
  input smlk_phase_e      phase,
  input logic             mem_valid,
  input logic             mem_smm,
  input logic             win_hit,
  input logic             sink_sel,
  input logic             smram_sel,
  input logic [DW-1:0]    hole_rdata
);

  assert_strap_inert_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!feat_en && cfg_wr) |=> $stable(cfg_rdata));

  assert_discard_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (phase == PH_OPEN && feat_en && cfg_wr && cfg_wdata != QUERY_VAL) |=> (cfg_rdata == 8'h00));

  assert_answer_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (phase == PH_OPEN && feat_en && cfg_wr && cfg_wdata == QUERY_VAL) |=> (cfg_rdata == ANSWER_VAL));

  assert_lock_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (phase == PH_ANSWERED && feat_en && cfg_wr && cfg_wdata[LOCK_BIT])
      |=> (cfg_rdata == LOCK_VAL && phase == PH_LOCKED));

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (phase == PH_LOCKED) |=> (phase == PH_LOCKED && cfg_rdata == LOCK_VAL));

  assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    $onehot0({sink_sel, smram_sel}));

  assert_fill_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    sink_sel |-> (hole_rdata == {DW{1'b1}} && !mem_smm));

  assert_smm_route_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    smram_sel |-> (mem_smm && mem_valid));

  assert_window_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (sink_sel || smram_sel) |-> (win_hit && mem_valid && phase == PH_LOCKED));

endmodule

bind smlk_top smlk_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .feat_en    (feat_en),
  .cfg_wr     (cfg_wr),
  .cfg_wdata  (cfg_wdata),
  .cfg_rdata  (cfg_rdata),
  .phase      (phase),
  .mem_valid  (mem_valid),
  .mem_smm    (mem_smm),
  .win_hit    (win_hit),
  .sink_sel   (sink_sel),
  .smram_sel  (smram_sel),
  .hole_rdata (hole_rdata)
);

// File: tb/smlk_top_tb_top.sv
module smlk_top_tb_top;

  typedef struct {
    string       req;
    string       tag;
    logic [7:0]  rd;
    logic        sink;
    logic        smram;
    logic [31:0] hrd;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic        feat_en;
  logic        cfg_wr;
  logic [7:0]  cfg_wdata;
  logic [7:0]  cfg_rdata;
  logic        mem_valid;
  logic        mem_smm;
  logic [31:0] mem_addr;
  logic        win_hit;
  logic        sink_sel;
  logic        smram_sel;
  logic [31:0] hole_rdata;

  int   checks;
  int   errors;
  bit   done;
  exp_t sb_q[$];

  smlk_top dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .feat_en    (feat_en),
    .cfg_wr     (cfg_wr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .mem_valid  (mem_valid),
    .mem_smm    (mem_smm),
    .mem_addr   (mem_addr),
    .win_hit    (win_hit),
    .sink_sel   (sink_sel),
    .smram_sel  (smram_sel),
    .hole_rdata (hole_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // monitor: pops expectations and compares against live outputs
  initial begin
    forever begin
      wait (sb_q.size() > 0);
      #1;
      begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (cfg_rdata !== e.rd || sink_sel !== e.sink || smram_sel !== e.smram ||
            hole_rdata !== e.hrd) begin
          errors++;
          $display("FAIL %s %s: rd=%h sink=%b smram=%b hrd=%h exp rd=%h sink=%b smram=%b hrd=%h",
                   e.req, e.tag, cfg_rdata, sink_sel, smram_sel, hole_rdata,
                   e.rd, e.sink, e.smram, e.hrd);
        end
      end
    end
  end

  task automatic expect_now(string req, string tag, logic [7:0] rd,
                            logic sink, logic smram);
    exp_t e;
    e.req = req; e.tag = tag; e.rd = rd; e.sink = sink; e.smram = smram;
    e.hrd = sink ? 32'hFFFF_FFFF : 32'h0;
    sb_q.push_back(e);
    #3;
  endtask

  task automatic do_reset(logic strap);
    @(negedge clk);
    rst_n = 1'b0; feat_en = strap; cfg_wr = 1'b0; mem_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic cfg_write(logic [7:0] d);
    @(negedge clk);
    mem_valid = 1'b0;
    cfg_wr = 1'b1; cfg_wdata = d;
    @(posedge clk);
    #2;
    cfg_wr = 1'b0;
  endtask

  task automatic access(logic [31:0] a, logic smm, logic vld);
    @(negedge clk);
    mem_addr = a; mem_smm = smm; mem_valid = vld;
    #2;
  endtask

  initial begin
    rst_n = 1'b0; feat_en = 1'b0; cfg_wr = 1'b0; cfg_wdata = '0;
    mem_valid = 1'b0; mem_smm = 1'b0; mem_addr = '0;

    // strap off
    do_reset(1'b0);
    expect_now("R1", "reset byte, strap off", 8'h00, 1'b0, 1'b0);
    cfg_write(8'hFF);
    expect_now("R2", "query ignored with strap off", 8'h00, 1'b0, 1'b0);
    cfg_write(8'h02);
    access(32'h0003_0000, 1'b0, 1'b1);
    expect_now("R2", "window unclaimed with strap off", 8'h00, 1'b0, 1'b0);

    // strap on, main handshake
    do_reset(1'b1);
    expect_now("R1", "reset byte", 8'h00, 1'b0, 1'b0);
    access(32'h0003_0000, 1'b0, 1'b1);
    expect_now("R1", "no routing after reset", 8'h00, 1'b0, 1'b0);
    cfg_write(8'h55);
    expect_now("R3", "pre-query write discarded", 8'h00, 1'b0, 1'b0);
    cfg_write(8'h02);
    expect_now("R3", "pre-query lock bit discarded", 8'h00, 1'b0, 1'b0);
    access(32'h0003_0000, 1'b0, 1'b1);
    expect_now("R3", "pre-query lock does not seal", 8'h00, 1'b0, 1'b0);
    cfg_write(8'hFF);
    expect_now("R4", "query answered", 8'h01, 1'b0, 1'b0);
    access(32'h0003_8000, 1'b1, 1'b1);
    expect_now("R9", "answered but not sealed", 8'h01, 1'b0, 1'b0);
    cfg_write(8'h00);
    expect_now("R4", "answer bit not writable", 8'h01, 1'b0, 1'b0);
    cfg_write(8'hFC & 8'hFD);
    expect_now("R4", "non-lock bits masked", 8'h01, 1'b0, 1'b0);
    cfg_write(8'h02);
    expect_now("R5", "lock reads exactly 0x02", 8'h02, 1'b0, 1'b0);
    cfg_write(8'h00);
    expect_now("R6", "locked after 0x00 write", 8'h02, 1'b0, 1'b0);
    cfg_write(8'hFF);
    expect_now("R6", "locked after 0xFF write", 8'h02, 1'b0, 1'b0);

    access(32'h0003_0000, 1'b0, 1'b1);
    expect_now("R7", "non-SMM at window base", 8'h02, 1'b1, 1'b0);
    access(32'h0003_FFFF, 1'b0, 1'b1);
    expect_now("R7", "non-SMM at window top", 8'h02, 1'b1, 1'b0);
    access(32'h0003_0000, 1'b1, 1'b1);
    expect_now("R8", "SMM at window base", 8'h02, 1'b0, 1'b1);
    access(32'h0003_FFFF, 1'b1, 1'b1);
    expect_now("R8", "SMM at window top", 8'h02, 1'b0, 1'b1);
    access(32'h0002_FFFF, 1'b0, 1'b1);
    expect_now("R9", "below window", 8'h02, 1'b0, 1'b0);
    access(32'h0004_0000, 1'b1, 1'b1);
    expect_now("R9", "above window", 8'h02, 1'b0, 1'b0);
    access(32'h0013_0000, 1'b0, 1'b1);
    expect_now("R9", "alias above window", 8'h02, 1'b0, 1'b0);
    access(32'h0003_1234, 1'b0, 1'b0);
    expect_now("R9", "invalid access", 8'h02, 1'b0, 1'b0);

    // second query seals
    do_reset(1'b1);
    expect_now("R1", "reset clears lock", 8'h00, 1'b0, 1'b0);
    cfg_write(8'hFF);
    expect_now("R10", "first query answered", 8'h01, 1'b0, 1'b0);
    cfg_write(8'hFF);
    expect_now("R10", "second query seals", 8'h02, 1'b0, 1'b0);
    access(32'h0003_4000, 1'b0, 1'b1);
    expect_now("R10", "sealed by second query", 8'h02, 1'b1, 1'b0);

    wait (sb_q.size() == 0);
    #5;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule